// File: doc/BRIEF.md
# Register-Bus SPI Master with Byte FIFOs

This block is a word-addressed peripheral that drives an SPI bus as master. Software writes bytes into a transmit queue. While the master-inhibit control bit is low, a shift engine sends the queued bytes one after another in SPI mode 0 (clock idles low, data sampled on the rising edge, MSB first). Every byte that is shifted out captures exactly one byte from `miso`, and that byte goes into a receive queue. Software reads it back through a data register.

Both queues are 8 bits wide and `DEPTH` entries deep (256 by default). A control register holds the inhibit bit and two self-clearing flush bits. A read-only status word reports the empty and full state of both queues, and two occupancy registers return live entry counts. A slave-select register drives the active-low chip selects directly. A keyed soft reset returns the whole block to its power-on state. Four registered one-cycle event pulses go to an interrupt block that lives outside this one.

The serial clock period is `CLK_DIV` system clocks. `CLK_DIV` is an even number of at least 2.

Top module: `spim_top`

## Requirements
- R1: After reset the status word reads 0x5, slave select reads 0xFFFFFFFF, all `cs_n` are high, control reads 0, and both occupancy registers read 0.
- R2: Only accesses with `bus_size`=2 (32-bit) take effect. Other sizes neither write nor pop, and they read 0. The byte offsets are: soft reset 0x40, control 0x60, status 0x64, TX data 0x68, RX data 0x6C, slave select 0x70, TX count 0x74, RX count 0x78. Any other offset reads 0.
- R3: Writing exactly 0xA to offset 0x40 clears control and both queues, and sets slave select to all ones. A write of any other value there changes nothing.
- R4: Writing control bit 5 empties the TX queue and writing control bit 6 empties the RX queue. Both bits always read back 0, and the other control bits are stored as written.
- R5: While control bit 8 is 1, queued bytes stay queued and `sclk` does not toggle. Writing bit 8 back to 0 starts sending the queued bytes.
- R6: Status bit 0 is RX empty, bit 1 is RX full, bit 2 is TX empty and bit 3 is TX full. Writes to the status word have no effect.
- R7: `sclk` idles low. Each byte is eight `sclk` pulses, with `mosi` carrying the MSB first and held stable across each rising edge. Each pulse lasts `CLK_DIV` system clocks.
- R8: Every sent byte stores one received byte, in the order sent. The bits are sampled from `miso` on the rising edges of `sclk`.
- R9: If the RX queue is full when a byte completes, that byte is dropped, the stored bytes are kept, and `ev_overrun` pulses.
- R10: A read of RX data while the RX queue is empty returns 0xDEADBEEF and leaves the queue unchanged.
- R11: Each queue holds `DEPTH` bytes. A TX data write while the TX queue is full is dropped. The occupancy registers return the current counts.
- R12: `cs_n[i]` equals bit i of the slave-select register, and 0 selects slave i.
- R13: `ev_rx_push` pulses once for each stored byte. `ev_rx_full` pulses when a store fills the RX queue. `ev_tx_drained` pulses when the engine takes the last queued TX byte. Each pulse appears one cycle after its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low chip selects |
| ev_overrun | output | 1 | Received byte dropped on a full RX queue |
| ev_rx_full | output | 1 | RX queue became full |
| ev_rx_push | output | 1 | A received byte was stored |
| ev_tx_drained | output | 1 | The engine took the last TX byte |

## Verification
A pointer or count that goes wrong in either queue shows up in the occupancy registers and the status word at the very next read. It also shows up as reordered or missing bytes when the RX data is read back. A fault in the shift engine appears on the serial pins within one byte time (`8*CLK_DIV` cycles): the number of `sclk` pulses is wrong, or the bits captured from `mosi` differ from the byte written. A bad gating or overrun decision shows up after one queue's worth of traffic, as a count that differs from 256 or as a missing or extra event pulse.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int BUS_AW = 7;

    // Register byte offsets
    localparam logic [BUS_AW-1:0] OFF_SRST  = 7'h40;
    localparam logic [BUS_AW-1:0] OFF_CTRL  = 7'h60;
    localparam logic [BUS_AW-1:0] OFF_STAT  = 7'h64;
    localparam logic [BUS_AW-1:0] OFF_TXD   = 7'h68;
    localparam logic [BUS_AW-1:0] OFF_RXD   = 7'h6C;
    localparam logic [BUS_AW-1:0] OFF_SSEL  = 7'h70;
    localparam logic [BUS_AW-1:0] OFF_TXOCC = 7'h74;
    localparam logic [BUS_AW-1:0] OFF_RXOCC = 7'h78;

    localparam logic [1:0]  SIZE_WORD    = 2'd2;
    localparam logic [31:0] SRST_KEY     = 32'h0000_000A;
    localparam logic [31:0] EMPTY_RDATA  = 32'hDEAD_BEEF;
    localparam int          CTRL_TXFLUSH = 5;
    localparam int          CTRL_RXFLUSH = 6;
    localparam int          CTRL_INHIBIT = 8;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_SRST, SEL_CTRL, SEL_STAT, SEL_TXD,
        SEL_RXD, SEL_SSEL, SEL_TXOCC, SEL_RXOCC
    } reg_sel_e;

    // Bit 3 down to bit 0 of the status word
    typedef struct packed {
        logic tx_full;
        logic tx_empty;
        logic rx_full;
        logic rx_empty;
    } stat_t;

    typedef struct packed {
        logic overrun;
        logic rx_full;
        logic rx_push;
        logic tx_drained;
    } evt_t;

    function automatic reg_sel_e decode_addr(input logic [BUS_AW-1:0] a);
        case (a)
            OFF_SRST:  return SEL_SRST;
            OFF_CTRL:  return SEL_CTRL;
            OFF_STAT:  return SEL_STAT;
            OFF_TXD:   return SEL_TXD;
            OFF_RXD:   return SEL_RXD;
            OFF_SSEL:  return SEL_SSEL;
            OFF_TXOCC: return SEL_TXOCC;
            OFF_RXOCC: return SEL_RXOCC;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 256,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
    parameter int CLK_DIV = 4,
    localparam int HALF   = CLK_DIV / 2,
    localparam int DW     = $clog2(HALF + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF - 1);

    logic [7:0]    tx_sh, rx_sh;
    logic [2:0]    bit_idx;
    logic [DW-1:0] div_cnt;

    assign mosi    = tx_sh[7];
    assign rx_byte = rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            sclk    <= 1'b0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            bit_idx <= '0;
            div_cnt <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    tx_sh   <= tx_byte;
                    bit_idx <= '0;
                    div_cnt <= '0;
                    sclk    <= 1'b0;
                end
            end else if (div_cnt == DIV_LAST) begin
                div_cnt <= '0;
                if (!sclk) begin
                    sclk  <= 1'b1;
                    rx_sh <= {rx_sh[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_idx == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                    end
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int NUM_CS  = 1,
    parameter int DEPTH   = 256,
    parameter int CLK_DIV = 4,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [1:0]          bus_size,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic [NUM_CS-1:0]   cs_n,
    output logic                ev_overrun,
    output logic                ev_rx_full,
    output logic                ev_rx_push,
    output logic                ev_tx_drained
);
    reg_sel_e    sel;
    logic        wr_acc, rd_acc, soft_rst_req, lrst;
    logic [31:0] ctrl_q, ssel_q;
    logic        inhibit;

    logic          tx_clr, tx_push, tx_full, tx_empty;
    logic [7:0]    tx_head;
    logic [CW-1:0] tx_cnt;
    logic          rx_clr, rx_pop, rx_pop_eff, rx_push_ok, rx_full, rx_empty;
    logic [7:0]    rx_head;
    logic [CW-1:0] rx_cnt;

    logic       launch, eng_busy, eng_done, ovr;
    logic [7:0] eng_rx;
    evt_t       evt_q, evt_nxt;
    stat_t      stat;

    // Bus decode: only word accesses do anything
    assign sel          = (bus_sel && bus_size == SIZE_WORD) ? decode_addr(bus_addr) : SEL_NONE;
    assign wr_acc       = bus_wr && (sel != SEL_NONE);
    assign rd_acc       = !bus_wr && (sel != SEL_NONE);
    assign soft_rst_req = wr_acc && sel == SEL_SRST && bus_wdata == SRST_KEY;
    assign lrst         = rst || soft_rst_req;
    assign inhibit      = ctrl_q[CTRL_INHIBIT];

    always_ff @(posedge clk) begin
        if (lrst) begin
            ctrl_q <= '0;
            ssel_q <= '1;
        end else if (wr_acc) begin
            if (sel == SEL_CTRL)
                ctrl_q <= bus_wdata & ~((32'd1 << CTRL_TXFLUSH) | (32'd1 << CTRL_RXFLUSH));
            if (sel == SEL_SSEL)
                ssel_q <= bus_wdata;
        end
    end

    assign cs_n = ssel_q[NUM_CS-1:0];

    // Queue control
    assign tx_clr  = lrst || (wr_acc && sel == SEL_CTRL && bus_wdata[CTRL_TXFLUSH]);
    assign rx_clr  = lrst || (wr_acc && sel == SEL_CTRL && bus_wdata[CTRL_RXFLUSH]);
    assign tx_push = wr_acc && sel == SEL_TXD;
    assign rx_pop  = rd_acc && sel == SEL_RXD;
    assign rx_pop_eff = rx_pop && !rx_empty;

    assign launch     = !inhibit && !eng_busy && !tx_empty && !tx_clr;
    assign ovr        = eng_done && !rx_clr && rx_full && !rx_pop_eff;
    assign rx_push_ok = eng_done && !rx_clr && !ovr;

    spim_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .clr(tx_clr), .push(tx_push), .pop(launch),
        .wdata(bus_wdata[7:0]), .head(tx_head), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .clr(rx_clr), .push(rx_push_ok), .pop(rx_pop),
        .wdata(eng_rx), .head(rx_head), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty)
    );

    spim_shifter #(.CLK_DIV(CLK_DIV)) u_eng (
        .clk(clk), .rst(lrst), .start(launch), .tx_byte(tx_head),
        .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    // Event pulses, registered
    always_comb begin
        evt_nxt.overrun    = ovr;
        evt_nxt.rx_push    = rx_push_ok;
        evt_nxt.rx_full    = rx_push_ok && !rx_pop_eff && rx_cnt == CW'(DEPTH - 1);
        evt_nxt.tx_drained = launch && !tx_push && tx_cnt == CW'(1);
    end

    always_ff @(posedge clk) begin
        if (lrst) evt_q <= '0;
        else      evt_q <= evt_nxt;
    end

    assign ev_overrun    = evt_q.overrun;
    assign ev_rx_full    = evt_q.rx_full;
    assign ev_rx_push    = evt_q.rx_push;
    assign ev_tx_drained = evt_q.tx_drained;

    // Read mux
    always_comb begin
        stat.tx_full  = tx_full;
        stat.tx_empty = tx_empty;
        stat.rx_full  = rx_full;
        stat.rx_empty = rx_empty;
        bus_rdata = '0;
        if (rd_acc) begin
            case (sel)
                SEL_CTRL:  bus_rdata = ctrl_q;
                SEL_STAT:  bus_rdata = {28'd0, stat};
                SEL_RXD:   bus_rdata = rx_empty ? EMPTY_RDATA : {24'd0, rx_head};
                SEL_SSEL:  bus_rdata = ssel_q;
                SEL_TXOCC: bus_rdata = 32'(tx_cnt);
                SEL_RXOCC: bus_rdata = 32'(rx_cnt);
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
    parameter int NUM_CS = 1,
    parameter int DEPTH  = 256,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              sclk,
    input logic              busy,
    input logic              inhibit,
    input logic [CW-1:0]     tx_cnt,
    input logic [CW-1:0]     rx_cnt,
    input logic              ev_overrun,
    input logic              ev_rx_full,
    input logic              ev_rx_push,
    input logic [NUM_CS-1:0] cs_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_size,
    input logic [6:0]        bus_addr,
    input logic [31:0]       bus_wdata
);
    assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

    assert_inhibit_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (inhibit && !busy) |=> !busy);

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

    assert_overrun_when_full_R9: assert property (@(posedge clk) disable iff (rst)
        ev_overrun |-> rx_cnt == CW'(DEPTH));

    assert_full_with_push_R13: assert property (@(posedge clk) disable iff (rst)
        ev_rx_full |-> ev_rx_push);

    assert_cs_follows_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_size == 2'd2 && bus_addr == 7'h70)
        |=> cs_n == $past(bus_wdata[NUM_CS-1:0]));
endmodule

bind spim_top spim_checker #(.NUM_CS(NUM_CS), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .sclk(sclk), .busy(eng_busy), .inhibit(inhibit),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .ev_overrun(ev_overrun),
    .ev_rx_full(ev_rx_full), .ev_rx_push(ev_rx_push), .cs_n(cs_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/tb_spim_top.sv
module tb_spim_top;
    localparam int NCS = 2;
    localparam int DEP = 256;
    localparam int DIV = 4;

    localparam logic [6:0] A_SRST = 7'h40, A_CTRL = 7'h60, A_STAT = 7'h64,
                           A_TXD = 7'h68, A_RXD = 7'h6C, A_SSEL = 7'h70,
                           A_TXOCC = 7'h74, A_RXOCC = 7'h78;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, miso;
    logic [NCS-1:0] cs_n;
    logic ev_overrun, ev_rx_full, ev_rx_push, ev_tx_drained;

    assign miso = ~mosi;   // slave model: returns the inverted bit

    spim_top #(.NUM_CS(NCS), .DEPTH(DEP), .CLK_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
        .cs_n(cs_n), .ev_overrun(ev_overrun), .ev_rx_full(ev_rx_full),
        .ev_rx_push(ev_rx_push), .ev_tx_drained(ev_tx_drained)
    );

    int checks = 0, fails = 0;
    int sclk_rises = 0, mon_bits = 0;
    logic [7:0] mon_sh = '0;
    logic [7:0] mon_q[$];
    logic [7:0] sent_q[$];
    int n_ovr = 0, n_full = 0, n_push = 0, n_drain = 0;
    logic [31:0] rv;

    always @(posedge sclk) begin
        sclk_rises++;
        mon_sh = {mon_sh[6:0], mosi};
        mon_bits++;
        if (mon_bits == 8) begin
            mon_q.push_back(mon_sh);
            mon_bits = 0;
        end
    end

    always @(posedge clk) begin
        if (!rst) begin
            if (ev_overrun)    n_ovr++;
            if (ev_rx_full)    n_full++;
            if (ev_rx_push)    n_push++;
            if (ev_tx_drained) n_drain++;
        end
    end

    function automatic logic [7:0] expect_rx(input logic [7:0] b);
        return ~b;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_sz(input logic [6:0] a, input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_size = 2'd2;
    endtask

    task automatic rd_sz(input logic [6:0] a, output logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_size = 2'd2;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        wr_sz(a, d, 2'd2);
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        rd_sz(a, d, 2'd2);
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(A_STAT, rv);  check("R1 status", rv, 32'h5);
        rd(A_SSEL, rv);  check("R1 slave select", rv, 32'hFFFF_FFFF);
        check("R1 cs_n", 32'(cs_n), 32'h3);
        rd(A_CTRL, rv);  check("R1 control", rv, 32'h0);
        rd(A_TXOCC, rv); check("R1 tx count", rv, 32'h0);
        rd(A_RXOCC, rv); check("R1 rx count", rv, 32'h0);
        rd(7'h04, rv);   check("R2 unmapped read", rv, 32'h0);

        // R5 inhibit, R2 size filtering
        wr(A_CTRL, 32'h100);
        wr_sz(A_TXD, 32'h55, 2'd0);
        rd(A_TXOCC, rv); check("R2 byte write ignored", rv, 32'h0);
        rd_sz(A_CTRL, rv, 2'd1); check("R2 half read is zero", rv, 32'h0);
        sent_q = '{8'hA5, 8'h3C, 8'h81};
        foreach (sent_q[i]) wr(A_TXD, 32'(sent_q[i]));
        rd(A_TXOCC, rv); check("R11 tx count", rv, 32'd3);
        rd(A_STAT, rv);  check("R6 status queued", rv, 32'h1);
        wr(A_STAT, 32'hF);
        rd(A_STAT, rv);  check("R6 status write ignored", rv, 32'h1);
        repeat (100) @(posedge clk);
        check("R5 no sclk while inhibited", 32'(sclk_rises), 32'd0);
        rd(A_RXOCC, rv); check("R5 nothing received", rv, 32'd0);

        // R7 / R8 release and transfer
        n_push = 0; n_drain = 0;
        wr(A_CTRL, 32'h0);
        repeat (3 * 40) @(posedge clk);
        check("R7 sclk pulses", 32'(sclk_rises), 32'd24);
        for (int i = 0; i < 3; i++)
            check("R7 mosi MSB first", 32'(mon_q[i]), 32'(sent_q[i]));
        rd(A_RXOCC, rv); check("R8 rx count", rv, 32'd3);
        for (int i = 0; i < 3; i++) begin
            rd(A_RXD, rv); check("R8 rx byte", rv, 32'(expect_rx(sent_q[i])));
        end
        rd(A_STAT, rv); check("R6 idle status", rv, 32'h5);
        check("R13 push pulses", 32'(n_push), 32'd3);
        check("R13 drained pulses", 32'(n_drain), 32'd1);

        // R10 empty read
        rd(A_RXD, rv);   check("R10 empty read", rv, 32'hDEAD_BEEF);
        rd(A_RXOCC, rv); check("R10 count unchanged", rv, 32'd0);

        // R12 chip selects
        wr(A_SSEL, 32'hFFFF_FFFE);
        @(negedge clk); check("R12 cs_n select 0", 32'(cs_n), 32'h2);
        wr(A_SSEL, 32'h1);
        @(negedge clk); check("R12 cs_n select 1", 32'(cs_n), 32'h1);
        rd(A_SSEL, rv); check("R12 readback", rv, 32'h1);

        // R11 / R9 fill both queues
        wr(A_CTRL, 32'h100);
        for (int i = 0; i < DEP; i++) wr(A_TXD, 32'(i));
        wr(A_TXD, 32'hEE);
        rd(A_TXOCC, rv); check("R11 full write dropped", rv, 32'd256);
        rd(A_STAT, rv);  check("R6 tx full", rv, 32'h9);
        n_ovr = 0; n_full = 0;
        wr(A_CTRL, 32'h0);
        repeat (DEP * 34 + 100) @(posedge clk);
        rd(A_RXOCC, rv); check("R11 rx count", rv, 32'd256);
        rd(A_STAT, rv);  check("R6 rx full", rv, 32'h6);
        check("R13 full pulse", 32'(n_full), 32'd1);
        check("R9 no early overrun", 32'(n_ovr), 32'd0);
        wr(A_TXD, 32'h77);
        repeat (60) @(posedge clk);
        check("R9 overrun pulse", 32'(n_ovr), 32'd1);
        rd(A_RXOCC, rv); check("R9 count kept", rv, 32'd256);
        for (int i = 0; i < 4; i++) begin
            rd(A_RXD, rv); check("R9 old bytes kept", rv, 32'(expect_rx(8'(i))));
        end

        // R4 flush bits
        wr(A_CTRL, 32'h40);
        rd(A_RXOCC, rv); check("R4 rx flushed", rv, 32'd0);
        rd(A_CTRL, rv);  check("R4 flush bit reads 0", rv, 32'h0);
        wr(A_CTRL, 32'h100);
        wr(A_TXD, 32'h11); wr(A_TXD, 32'h22);
        wr(A_CTRL, 32'h120);
        rd(A_TXOCC, rv); check("R4 tx flushed", rv, 32'd0);
        rd(A_CTRL, rv);  check("R4 other bits kept", rv, 32'h100);

        // R3 soft reset key
        wr(A_TXD, 32'h33);
        wr(A_SSEL, 32'h0);
        wr(A_SRST, 32'h5);
        rd(A_CTRL, rv);  check("R3 wrong key ignored ctrl", rv, 32'h100);
        rd(A_TXOCC, rv); check("R3 wrong key ignored txq", rv, 32'd1);
        wr(A_SRST, 32'hA);
        rd(A_CTRL, rv);  check("R3 ctrl cleared", rv, 32'h0);
        rd(A_TXOCC, rv); check("R3 txq cleared", rv, 32'd0);
        rd(A_SSEL, rv);  check("R3 select ones", rv, 32'hFFFF_FFFF);
        check("R3 cs_n high", 32'(cs_n), 32'h3);
        rd(A_STAT, rv);  check("R3 status", rv, 32'h5);

        // R8 random bursts
        void'($urandom(32'd2024));
        for (int b = 0; b < 4; b++) begin
            int n;
            n = 1 + int'($urandom % 6);
            sent_q.delete();
            wr(A_CTRL, 32'h100);
            for (int i = 0; i < n; i++) begin
                logic [7:0] x;
                x = 8'($urandom);
                sent_q.push_back(x);
                wr(A_TXD, 32'(x));
            end
            wr(A_CTRL, 32'h0);
            repeat (n * 40 + 20) @(posedge clk);
            rd(A_RXOCC, rv); check("R8 random count", rv, 32'(n));
            for (int i = 0; i < n; i++) begin
                rd(A_RXD, rv); check("R8 random byte", rv, 32'(expect_rx(sent_q[i])));
            end
        end

        finish_run();
    end
endmodule